// File: doc/BRIEF.md
# Cache Maintenance Command Dispatcher

This block takes one seven-word command descriptor at a time from a command ring. It decodes a 4-bit maintenance opcode and checks the opcode and the reserved fields. A legal command goes to one of two search engines, picked by a select bit. The request carries a 40-bit control buffer address, the opcode and a byte-swap flag.

When the chosen engine signals done, the block builds a status record and offers it on one of two status rings, picked per command. The record carries:
- the 64-bit caller metadata, unchanged;
- the opcode and the engine select;
- an error flag;
- a statistics value with a flag that says whether the value is meaningful.

A command with a reserved opcode or nonzero reserved bits is not sent to any engine. It goes straight to an error status on its selected ring.

Only one command is in flight at a time. The command input stays not-ready from acceptance until the status record has been taken by its ring.

Top module: `maint_cmd_dispatch`

## Requirements
- R1: `cmd_ready_o` is high whenever no command is in flight. It goes low in the cycle after a command is accepted and stays low until the cycle after the status handshake completes.
- R2: The command is seven 32-bit words, with word k at `cmd_i[32k+31:32k]`. The engine address is {word1[7:0], word0}, and it is presented on `eng_addr_o` while the request is active.
- R3: The opcode is word1[11:8]. Values 0 to 8 are legal and are driven on `eng_op_o`. Values 9 to 15 raise no engine request and produce a status with `sts_err_o`=1. The opcode meanings are: 0 read statistics, 1 hash-only lookup, 2 write back one entry, 3 write back all, 4 invalidate one, 5 invalidate all, 6 write back and invalidate one, 7 write back and invalidate all, 8 clear statistics of one entry.
- R4: The reserved bits are word1[31:15], word4, word5 and word6[19:0]. If any of them is nonzero, no engine request is raised and the status has `sts_err_o`=1. Word6[31:20] has no effect.
- R5: Word1[12] selects the engine: 0 raises `eng_req_o[0]` and 1 raises `eng_req_o[1]`. At most one request bit is high at any time.
- R6: A request stays high until the selected engine pulses its bit of `eng_done_i`. A done pulse from the other engine is ignored.
- R7: Word1[13] selects the status ring: 0 raises `sts_valid_o[0]` and 1 raises `sts_valid_o[1]`. Valid and the status fields hold until that ring's `sts_ready_i` bit is high. A ready on the other ring has no effect.
- R8: `sts_meta_o` equals {word3, word2} of the command.
- R9: `sts_stats_valid_o` is 1 exactly for legal, error-free opcodes 0, 2, 4, 6 and 8. `sts_stat_o` is then the selected engine's `eng_stat_i` slice, sampled in its done cycle, and is zero otherwise.
- R10: Word1[14] is driven on `eng_swap_o` while the request is active.
- R11: After reset, no engine request and no status valid is high.
- R12: `sts_op_o` and `sts_eng_o` echo the opcode and the engine select of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command descriptor valid |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_i | input | 224 | Seven-word command descriptor |
| eng_req_o | output | 2 | Request, one bit per engine |
| eng_op_o | output | 4 | Maintenance opcode |
| eng_addr_o | output | 40 | Control buffer address |
| eng_swap_o | output | 1 | Byte-swap enable for the buffer |
| eng_done_i | input | 2 | Completion pulse, one bit per engine |
| eng_stat_i | input | 2*STAT_W | Statistics value, one slice per engine |
| sts_valid_o | output | 2 | Status valid, one bit per ring |
| sts_ready_i | input | 2 | Status ready, one bit per ring |
| sts_meta_o | output | 64 | Echoed caller metadata |
| sts_op_o | output | 4 | Echoed opcode |
| sts_eng_o | output | 1 | Echoed engine select |
| sts_err_o | output | 1 | Command rejected |
| sts_stats_valid_o | output | 1 | Statistics value is meaningful |
| sts_stat_o | output | STAT_W | Statistics value |

## Verification
The bench walks the opcode boundary 8/9 and opcode 15. A design that compared against the wrong limit would either dispatch a reserved code or reject the statistics-clear command.

Each reserved region is set nonzero on its own, while word6[31:20] is filled with random values. A decoder that missed a region would send that command to an engine, and one that checked too much would reject legal commands.

While waiting, the bench pulses done on the engine that was not selected and asserts ready on the ring that was not selected. Wrong steering would end the transaction early.

The engine statistics inputs are changed after the done cycle, and the odd, hash-only and error cases are mixed in. This catches a design that passes statistics through combinationally or that flags them for the wrong opcodes.

// File: rtl/maint_pkg.sv
package maint_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 7;
  localparam int CMD_W     = WORD_W * NUM_WORDS;
  localparam int ADDR_W    = 40;
  localparam int META_W    = 64;
  localparam int OP_W      = 4;
  localparam int NUM_ENG   = 2;
  localparam int NUM_RING  = 2;

  localparam logic [OP_W-1:0] OP_RD_STAT   = 4'd0;
  localparam logic [OP_W-1:0] OP_HASH_ONLY = 4'd1;
  localparam logic [OP_W-1:0] OP_WB_ONE    = 4'd2;
  localparam logic [OP_W-1:0] OP_WB_ALL    = 4'd3;
  localparam logic [OP_W-1:0] OP_INV_ONE   = 4'd4;
  localparam logic [OP_W-1:0] OP_INV_ALL   = 4'd5;
  localparam logic [OP_W-1:0] OP_WBI_ONE   = 4'd6;
  localparam logic [OP_W-1:0] OP_WBI_ALL   = 4'd7;
  localparam logic [OP_W-1:0] OP_CLR_STAT  = 4'd8;
  localparam logic [OP_W-1:0] OP_MAX       = OP_CLR_STAT;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_STS} state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [OP_W-1:0]   op;
    logic              eng_sel;
    logic              ring_sel;
    logic              swap;
    logic [META_W-1:0] meta;
    logic              err;
    logic              stats;
  } cmd_t;

  // single-entry ops and read stats are exactly the even legal codes
  function automatic logic op_reports_stats(input logic [OP_W-1:0] op);
    return (op <= OP_MAX) && !op[0];
  endfunction
endpackage

// File: rtl/maint_cmd_decode.sv
module maint_cmd_decode
  import maint_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_t             dec_o
);
  logic [WORD_W-1:0] w [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_unpack
    assign w[g] = cmd_i[g*WORD_W +: WORD_W];
  end

  logic rsvd_bad, op_bad;
  assign rsvd_bad = (|w[1][31:15]) | (|w[4]) | (|w[5]) | (|w[6][19:0]);
  assign op_bad   = w[1][11:8] > OP_MAX;

  always_comb begin
    dec_o          = '0;
    dec_o.addr     = {w[1][7:0], w[0]};
    dec_o.op       = w[1][11:8];
    dec_o.eng_sel  = w[1][12];
    dec_o.ring_sel = w[1][13];
    dec_o.swap     = w[1][14];
    dec_o.meta     = {w[3], w[2]};
    dec_o.err      = rsvd_bad | op_bad;
    dec_o.stats    = !(rsvd_bad | op_bad) && op_reports_stats(w[1][11:8]);
  end
endmodule

// File: rtl/maint_eng_route.sv
module maint_eng_route
  import maint_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic                      active_i,
  input  logic                      sel_i,
  input  logic [NUM_ENG-1:0]        done_i,
  input  logic [NUM_ENG*STAT_W-1:0] stat_i,
  output logic [NUM_ENG-1:0]        req_o,
  output logic                      done_o,
  output logic [STAT_W-1:0]         stat_o
);
  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    assign req_o[g] = active_i && (int'(sel_i) == g);
  end

  assign done_o = |(req_o & done_i);
  assign stat_o = stat_i[int'(sel_i)*STAT_W +: STAT_W];
endmodule

// File: rtl/maint_sts_steer.sv
module maint_sts_steer
  import maint_pkg::*;
(
  input  logic                active_i,
  input  logic                sel_i,
  input  logic [NUM_RING-1:0] ready_i,
  output logic [NUM_RING-1:0] valid_o,
  output logic                accept_o
);
  for (genvar g = 0; g < NUM_RING; g++) begin : g_ring
    assign valid_o[g] = active_i && (int'(sel_i) == g);
  end

  assign accept_o = |(valid_o & ready_i);
endmodule

// File: rtl/maint_cmd_dispatch.sv
module maint_cmd_dispatch
  import maint_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  output logic                      cmd_ready_o,
  input  logic [CMD_W-1:0]          cmd_i,
  output logic [NUM_ENG-1:0]        eng_req_o,
  output logic [OP_W-1:0]           eng_op_o,
  output logic [ADDR_W-1:0]         eng_addr_o,
  output logic                      eng_swap_o,
  input  logic [NUM_ENG-1:0]        eng_done_i,
  input  logic [NUM_ENG*STAT_W-1:0] eng_stat_i,
  output logic [NUM_RING-1:0]       sts_valid_o,
  input  logic [NUM_RING-1:0]       sts_ready_i,
  output logic [META_W-1:0]         sts_meta_o,
  output logic [OP_W-1:0]           sts_op_o,
  output logic                      sts_eng_o,
  output logic                      sts_err_o,
  output logic                      sts_stats_valid_o,
  output logic [STAT_W-1:0]         sts_stat_o
);
  state_e            state_q;
  cmd_t              dec, cmd_q;
  logic [STAT_W-1:0] stat_q, sel_stat;
  logic              sel_done, sts_accept;

  maint_cmd_decode u_dec (.cmd_i(cmd_i), .dec_o(dec));

  maint_eng_route #(.STAT_W(STAT_W)) u_route (
    .active_i(state_q == S_REQ),
    .sel_i   (cmd_q.eng_sel),
    .done_i  (eng_done_i),
    .stat_i  (eng_stat_i),
    .req_o   (eng_req_o),
    .done_o  (sel_done),
    .stat_o  (sel_stat)
  );

  maint_sts_steer u_steer (
    .active_i(state_q == S_STS),
    .sel_i   (cmd_q.ring_sel),
    .ready_i (sts_ready_i),
    .valid_o (sts_valid_o),
    .accept_o(sts_accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      stat_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          cmd_q   <= dec;
          stat_q  <= '0;
          state_q <= dec.err ? S_STS : S_REQ;
        end
        S_REQ: if (sel_done) begin
          stat_q  <= cmd_q.stats ? sel_stat : '0;
          state_q <= S_STS;
        end
        S_STS: if (sts_accept) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o       = state_q == S_IDLE;
  assign eng_op_o          = cmd_q.op;
  assign eng_addr_o        = cmd_q.addr;
  assign eng_swap_o        = cmd_q.swap;
  assign sts_meta_o        = cmd_q.meta;
  assign sts_op_o          = cmd_q.op;
  assign sts_eng_o         = cmd_q.eng_sel;
  assign sts_err_o         = cmd_q.err;
  assign sts_stats_valid_o = cmd_q.stats;
  assign sts_stat_o        = stat_q;

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|eng_req_o) || (|sts_valid_o)) |-> !cmd_ready_o); // R1
  AST_ERR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && dec.err) |=> (eng_req_o == '0)); // R3
  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eng_req_o)); // R5
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|eng_req_o) && !(|(eng_req_o & eng_done_i))) |=> (eng_req_o == $past(eng_req_o))); // R6
  AST_STS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sts_valid_o)); // R7
  AST_STS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sts_valid_o) && !(|(sts_valid_o & sts_ready_i)))
      |=> (sts_valid_o == $past(sts_valid_o)) && $stable(sts_meta_o) && $stable(sts_stat_o)); // R7
  AST_ERR_NO_STATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sts_valid_o) && sts_err_o) |-> !sts_stats_valid_o && (sts_stat_o == '0)); // R9
endmodule

// File: tb/maint_cmd_dispatch_tb_top.sv
module maint_cmd_dispatch_tb_top;
  import maint_pkg::*;
  localparam int STAT_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                      cmd_valid = 1'b0;
  logic                      cmd_ready;
  logic [CMD_W-1:0]          cmd = '0;
  logic [NUM_ENG-1:0]        eng_req;
  logic [OP_W-1:0]           eng_op;
  logic [ADDR_W-1:0]         eng_addr;
  logic                      eng_swap;
  logic [NUM_ENG-1:0]        eng_done = '0;
  logic [NUM_ENG*STAT_W-1:0] eng_stat = '0;
  logic [NUM_RING-1:0]       sts_valid;
  logic [NUM_RING-1:0]       sts_ready = '0;
  logic [META_W-1:0]         sts_meta;
  logic [OP_W-1:0]           sts_op;
  logic                      sts_eng, sts_err, sts_sv;
  logic [STAT_W-1:0]         sts_stat;

  maint_cmd_dispatch #(.STAT_W(STAT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_i(cmd),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_addr_o(eng_addr), .eng_swap_o(eng_swap),
    .eng_done_i(eng_done), .eng_stat_i(eng_stat), .sts_valid_o(sts_valid), .sts_ready_i(sts_ready),
    .sts_meta_o(sts_meta), .sts_op_o(sts_op), .sts_eng_o(sts_eng), .sts_err_o(sts_err),
    .sts_stats_valid_o(sts_sv), .sts_stat_o(sts_stat)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CMD_W-1:0] build(input logic [ADDR_W-1:0] addr, input logic [3:0] op,
      input bit esel, input bit rsel, input bit swap, input logic [63:0] meta, input int rsvd);
    logic [WORD_W-1:0] w [NUM_WORDS];
    logic [CMD_W-1:0] v;
    w[0] = addr[31:0];
    w[1] = {17'd0, swap, rsel, esel, op, addr[39:32]};
    w[2] = meta[31:0];
    w[3] = meta[63:32];
    w[4] = '0;
    w[5] = '0;
    w[6] = {$urandom_range(4095, 0), 20'd0};  // ring id and loop count: no effect
    case (rsvd)
      1: w[1][15 + $urandom_range(16, 0)] = 1'b1;
      2: w[4][$urandom_range(31, 0)] = 1'b1;
      3: w[5][$urandom_range(31, 0)] = 1'b1;
      4: w[6][$urandom_range(19, 0)] = 1'b1;
      default: ;
    endcase
    for (int k = 0; k < NUM_WORDS; k++) v[k*WORD_W +: WORD_W] = w[k];
    return v;
  endfunction

  function automatic bit exp_stats(input logic [3:0] op, input bit err);
    return !err && (op <= 4'd8) && !op[0];
  endfunction

  task automatic run_cmd(input logic [3:0] op, input bit esel, input bit rsel, input int rsvd,
                         input int dly, input int sdly, input bit noise);
    logic [ADDR_W-1:0] addr = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
    logic [63:0] meta = {$urandom, $urandom};
    bit swap = 1'($urandom);
    bit err = (op > 4'd8) || (rsvd != 0);
    bit sv = exp_stats(op, err);
    logic [STAT_W-1:0] stat_e = '0;
    check(cmd_ready == 1'b1, "R1 idle ready", 64'(cmd_ready), 64'd1);
    cmd = build(addr, op, esel, rsel, swap, meta, rsvd);
    cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    cmd = {7{$urandom}};
    check(cmd_ready == 1'b0, "R1 busy", 64'(cmd_ready), 64'd0);
    if (err) begin
      check(eng_req == 2'b00, op > 4'd8 ? "R3 reserved op no req" : "R4 reserved bits no req",
            64'(eng_req), 64'd0);
    end else begin
      check(eng_req == (2'b01 << esel), "R5 engine select", 64'(eng_req), 64'(2'b01 << esel));
      check(eng_op == op, "R3 opcode", 64'(eng_op), 64'(op));
      check(eng_addr == addr, "R2 address", 64'(eng_addr), 64'(addr));
      check(eng_swap == swap, "R10 swap", 64'(eng_swap), 64'(swap));
      for (int i = 0; i < dly; i++) begin
        if (noise) eng_done[!esel] = 1'b1;
        @(posedge clk); @(negedge clk);
        eng_done = '0;
        check(eng_req == (2'b01 << esel), "R6 request held", 64'(eng_req), 64'(2'b01 << esel));
      end
      eng_stat = {$urandom, $urandom};
      stat_e = sv ? eng_stat[int'(esel)*STAT_W +: STAT_W] : '0;
      eng_done[esel] = 1'b1;
      @(posedge clk); @(negedge clk);
      eng_done = '0;
      eng_stat = {$urandom, $urandom};
      check(eng_req == 2'b00, "R6 request drops", 64'(eng_req), 64'd0);
    end
    check(sts_valid == (2'b01 << rsel), "R7 ring steer", 64'(sts_valid), 64'(2'b01 << rsel));
    check(sts_meta == meta, "R8 metadata", sts_meta, meta);
    check(sts_err == err, "R3 R4 error flag", 64'(sts_err), 64'(err));
    check(sts_sv == sv, "R9 stats valid", 64'(sts_sv), 64'(sv));
    check(sts_stat == stat_e, "R9 stat value", 64'(sts_stat), 64'(stat_e));
    check(sts_op == op && sts_eng == esel, "R12 echo", 64'({sts_eng, sts_op}), 64'({esel, op}));
    for (int i = 0; i < sdly; i++) begin
      sts_ready = 2'b01 << !rsel;
      @(posedge clk); @(negedge clk);
      check(sts_valid == (2'b01 << rsel) && sts_meta == meta, "R7 status held",
            64'(sts_valid), 64'(2'b01 << rsel));
      check(cmd_ready == 1'b0, "R1 busy in status", 64'(cmd_ready), 64'd0);
    end
    sts_ready = 2'b01 << rsel;
    @(posedge clk); @(negedge clk);
    sts_ready = '0;
    check(sts_valid == 2'b00, "R7 status taken", 64'(sts_valid), 64'd0);
    check(cmd_ready == 1'b1, "R1 ready after status", 64'(cmd_ready), 64'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(eng_req == 2'b00 && sts_valid == 2'b00, "R11 reset outputs",
          64'({eng_req, sts_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && eng_req == 2'b00 && sts_valid == 2'b00, "R11 after reset",
          64'({cmd_ready, eng_req, sts_valid}), 64'h10);
    for (int o = 0; o <= 8; o++) run_cmd(4'(o), 1'(o), 1'(o >> 1), 0, o % 3, o % 2, 1'b1);
    run_cmd(4'd9, 1'b0, 1'b1, 0, 0, 1, 1'b0);
    run_cmd(4'd15, 1'b1, 1'b0, 0, 0, 0, 1'b0);
    for (int r = 1; r <= 4; r++) run_cmd(4'd2, 1'(r), 1'(r >> 1), r, 1, 1, 1'b0);
    run_cmd(4'd8, 1'b1, 1'b1, 0, 0, 0, 1'b0);
    for (int n = 0; n < 200; n++) begin
      logic [3:0] op = ($urandom_range(3, 0) == 0) ? 4'($urandom_range(15, 9)) : 4'($urandom_range(8, 0));
      int rs = ($urandom_range(7, 0) == 0) ? int'($urandom_range(4, 1)) : 0;
      run_cmd(op, 1'($urandom), 1'($urandom), rs, int'($urandom_range(4, 0)),
              int'($urandom_range(3, 0)), 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule